// File: doc/BRIEF.md
# Transmit Page Chain Initializer

This block writes the next-pointer table that links the pages of a transmit buffer. After a start pulse it takes two page indices, a split point and a final entry, and fills the table in one pass. Pages below the split form a forward list whose last member holds an end marker. Pages from the split up to the final entry form a loop whose final member points back to the split. The table RAM sits inside the block, and a registered read port lets the buffer logic, or a bench, walk the links.

Nothing is written into the table directly. Each entry goes through a command register that holds an entry address, a data value and an operation code. The register's operation field stays busy for a programmable number of cycles, and the sequencer polls it until it reads idle again. If the field stays busy for more polls than a parameter allows, the whole run stops and the failing entry is reported. The sequencer, the command register with its busy model, the link function and the table are all in this block. All control and status pins are plain level or pulse signals. There is no streaming interface, so there is no back-pressure to describe.

Top module: `pgchain_init`

## Requirements
- R1: After reset, busy, done and fail are all low.
- R2: Each entry is sent as one command with an address, a data value and operation code WRITE (2'b01). The operation field reads WRITE for busy_lat+1 cycles after the command and then reads IDLE (2'b00). The table is updated in the last busy cycle.
- R3: For 1 <= split <= final, each entry i with i < split-1 receives i+1.
- R4: Entry split-1 receives the end marker, which is all ones (8'hFF at the default width).
- R5: Each entry i with split <= i < final receives i+1.
- R6: Entry final receives the split index, which closes the loop.
- R7: Entries are written one at a time in ascending address order, which runs the four phases in order: list body, terminator, loop body, loop closure. A command is sent only after the previous write has polled idle. A successful run holds busy for exactly (final+1)*(busy_lat+3) cycles.
- R8: If the operation field is seen busy on more than POLL_LIMIT consecutive polls, the run aborts. This happens when busy_lat >= POLL_LIMIT. fail rises, fail_addr gives the entry being written, done does not pulse, and busy lasts POLL_LIMIT+2 cycles.
- R9: A start pulse while busy is high is ignored. It does not change the run in progress or the table it produces.
- R10: done is high for exactly one cycle, namely the first cycle in which busy is low again. fail stays high until the next start is accepted.
- R11: Entries above final keep their previous contents through a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when the block is idle |
| boundary | input | ADDR_W | Split index (first page of the loop) |
| last_idx | input | ADDR_W | Index of the final table entry |
| busy_lat | input | LAT_W | Extra busy cycles the command register shows per write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |
| fail | output | 1 | Sticky abort flag after a poll timeout |
| fail_addr | output | ADDR_W | Entry whose write timed out |
| rd_addr | input | ADDR_W | Table read address |
| rd_data | output | DATA_W | Table data, one cycle after rd_addr |

## Verification
The bench builds the block with a 16-entry table (ADDR_W=4), 8-bit data, a 3-bit latency input and POLL_LIMIT=4. With these values the bench can sweep every legal pair of split and final index while the busy latency cycles through 0 to 3, so the limit case busy_lat = POLL_LIMIT-1 passes. Latencies 4 to 7 fall on the timeout side. After each run the bench reads the whole table back. Because the final index decreases across the sweep, the entries above it are still known from earlier runs and can be compared.

// File: rtl/pgchain_pkg.sv
package pgchain_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ISSUE = 2'b01,
    S_POLL  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/pgchain_link_fn.sv
module pgchain_link_fn #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] idx,
  input  logic [ADDR_W-1:0] split,
  input  logic [ADDR_W-1:0] final_idx,
  output logic [DATA_W-1:0] link
);
  localparam logic [DATA_W-1:0] END_MARK = '1;

  logic [ADDR_W-1:0] idx_inc;
  logic [ADDR_W-1:0] split_dec;

  assign idx_inc   = idx + 1'b1;
  assign split_dec = split - 1'b1;

  // loop closure wins over the plain successor; terminator sits at split-1
  always_comb begin
    if (idx == final_idx)
      link = DATA_W'(split);
    else if (idx == split_dec)
      link = END_MARK;
    else
      link = DATA_W'(idx_inc);
  end
endmodule

// File: rtl/pgchain_table.sv
module pgchain_table #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pgchain_cmd_port.sv
module pgchain_cmd_port
  import pgchain_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  op_e               cmd_op,
  input  logic [LAT_W-1:0]  busy_lat,
  output op_e               stat_op,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  op_e               op_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (cmd_valid && cmd_op == OP_WRITE) begin
      op_q   <= OP_WRITE;
      cnt_q  <= busy_lat;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end else if (op_q == OP_WRITE) begin
      if (cnt_q == '0)
        op_q <= OP_IDLE;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign stat_op = op_q;
  assign wr_en   = (op_q == OP_WRITE) && (cnt_q == '0);
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R2: an accepted write command makes the field read busy next cycle
  assert_cmd_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_WRITE) |=> (stat_op == OP_WRITE));

  // R2: the field only returns to idle right after the table was written
  assert_idle_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_op) == OP_WRITE && stat_op == OP_IDLE) |-> $past(wr_en));
endmodule

// File: rtl/pgchain_seq.sv
module pgchain_seq
  import pgchain_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int POLL_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] boundary,
  input  logic [ADDR_W-1:0] last_idx,
  input  logic [DATA_W-1:0] link_data,
  input  op_e               stat_op,
  output logic [ADDR_W-1:0] cur_idx,
  output logic [ADDR_W-1:0] split_q,
  output logic [ADDR_W-1:0] final_q,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output op_e               cmd_op,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int PCNT_W = $clog2(POLL_LIMIT + 2);
  localparam logic [PCNT_W-1:0] PLIM = PCNT_W'(POLL_LIMIT);

  seq_state_e        state_q;
  logic [PCNT_W-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_idx   <= '0;
      split_q   <= '0;
      final_q   <= '0;
      pcnt_q    <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            split_q <= boundary;
            final_q <= last_idx;
            cur_idx <= '0;
            fail    <= 1'b0;
            state_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          pcnt_q  <= '0;
          state_q <= S_POLL;
        end
        S_POLL: begin
          if (stat_op == OP_IDLE) begin
            if (cur_idx == final_q) begin
              done    <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              cur_idx <= cur_idx + 1'b1;
              state_q <= S_ISSUE;
            end
          end else if (pcnt_q >= PLIM) begin
            fail      <= 1'b1;
            fail_addr <= cur_idx;
            state_q   <= S_IDLE;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign cmd_valid = (state_q == S_ISSUE);
  assign cmd_addr  = cur_idx;
  assign cmd_data  = link_data;
  assign cmd_op    = OP_WRITE;

  // R7: every command after the first follows an idle poll of the previous write
  assert_issue_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cur_idx != '0) |-> ($past(stat_op) == OP_IDLE));

  // R9: the latched indices do not move while a run is active
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(split_q) && $stable(final_q)));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: fail holds until a new start
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  // R8: an aborted run never reports completion
  assert_no_done_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

// File: rtl/pgchain_init.sv
module pgchain_init
  import pgchain_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int LAT_W      = 4,
  parameter int POLL_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] boundary,
  input  logic [ADDR_W-1:0] last_idx,
  input  logic [LAT_W-1:0]  busy_lat,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] cur_idx, split_q, final_q;
  logic [DATA_W-1:0] link_data;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  op_e               cmd_op;
  op_e               stat_op;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  pgchain_link_fn #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_link (
    .idx(cur_idx), .split(split_q), .final_idx(final_q), .link(link_data)
  );

  pgchain_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .boundary(boundary),
    .last_idx(last_idx), .link_data(link_data), .stat_op(stat_op),
    .cur_idx(cur_idx), .split_q(split_q), .final_q(final_q),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_op(cmd_op), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr)
  );

  pgchain_cmd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_op(cmd_op), .busy_lat(busy_lat),
    .stat_op(stat_op), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  pgchain_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_pgchain_init.sv
module tb_pgchain_init;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int LW   = 3;
  localparam int PLIM = 4;
  localparam int N    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] boundary = '0;
  logic [AW-1:0] last_idx = '0;
  logic [LW-1:0] busy_lat = '0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_tab [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgchain_init #(.ADDR_W(AW), .DATA_W(DW), .LAT_W(LW), .POLL_LIMIT(PLIM)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .boundary(boundary),
    .last_idx(last_idx), .busy_lat(busy_lat), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] link_of(input int i, input int b, input int l);
    if (i == l) return DW'(b);
    if (i == b - 1) return '1;
    return DW'(i + 1);
  endfunction

  // one run; poke=1 pulses start with other indices mid-run (R9)
  task automatic run(input int b, input int l, input int lat, input bit poke);
    int cnt;
    @(negedge clk);
    boundary = AW'(b); last_idx = AW'(l); busy_lat = LW'(lat); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 fail cleared by start", int'(fail), 0);
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      @(negedge clk);
      if (poke && cnt == 3) begin
        start = 1'b1; boundary = AW'(1); last_idx = AW'(2);
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    if (lat >= PLIM) begin
      check("R8 busy length on timeout", cnt, PLIM + 2);
      check("R8 fail raised", int'(fail), 1);
      check("R8 fail_addr", int'(fail_addr), 0);
      check("R8 no done", int'(done), 0);
      @(negedge clk);
      check("R10 fail held", int'(fail), 1);
      exp_tab[0] = link_of(0, b, l);
      repeat (lat + 2) @(negedge clk);
    end else begin
      check("R7 R2 busy length", cnt, (l + 1) * (lat + 3));
      check("R10 done in first idle cycle", int'(done), 1);
      @(negedge clk);
      check("R10 done one cycle", int'(done), 0);
      for (int i = 0; i <= l; i++) exp_tab[i] = link_of(i, b, l);
    end
  endtask

  task automatic readback(input int b, input int l);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      rd_addr = AW'(i);
      @(negedge clk);
      if (i > l)           check("R11 untouched entry", int'(rd_data), int'(exp_tab[i]));
      else if (i == l)     check("R6 loop closure", int'(rd_data), int'(exp_tab[i]));
      else if (i == b - 1) check("R4 end marker", int'(rd_data), int'(exp_tab[i]));
      else if (i < b - 1)  check("R3 list body", int'(rd_data), int'(exp_tab[i]));
      else                 check("R5 loop body", int'(rd_data), int'(exp_tab[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 fail after reset", int'(fail), 0);
    rst_n = 1'b1;
    // decreasing final index keeps upper entries known for R11
    for (int l = N - 1; l >= 1; l--) begin
      for (int b = 1; b <= l; b++) begin
        run(b, l, (b + l) % 4, 1'b0);
        readback(b, l);
      end
    end
    // R9: start pulse mid-run must not disturb the table
    run(5, 12, 2, 1'b1);
    readback(5, 12);
    // R8: latencies at and past the poll limit
    run(3, 9, 4, 1'b0);
    readback(3, 9);
    run(1, 6, 7, 1'b0);
    readback(1, 6);
    run(7, 15, 3, 1'b0);
    readback(7, 15);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule